// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

The core executes a small 32-bit load/store instruction set and completes every instruction in one clock cycle. On each rising edge the program counter, one general-purpose register and one data word may change. All three are computed from the instruction that the current PC selects. The core holds a 32-entry register file, an instruction memory and a data memory. Both memories read combinationally and are word arrays.

Programs and data are placed in the memories through a load port. This is normally done while reset is held. Once reset is released, the core fetches from address 0. Observation outputs show the current PC and instruction, the register write, and the data store of the instruction in flight. A combinational peek port reads any data word.

Top module: `sc_core32`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and clears all registers. After the first clock edge with `rst` high, `pc_o` reads 0.
- R2: The R-type format has opcode 0 in bits [31:26], rs in [25:21], rt in [20:16], rd in [15:11] and the function in [5:0]. The function codes are 0x20 add, 0x22 sub, 0x24 and, 0x25 or and 0x2A signed set-less-than. The result of R[rs] op R[rt] is written to rd. A function code outside this list writes nothing.
- R3: Opcode 13 writes R[rs] OR zero-extended imm16 (bits [15:0]) into rt.
- R4: Opcode 35 loads the data word at R[rs] + sign-extended imm16 into rt. Opcode 43 stores R[rt] at that address and writes no register. Memories use byte address bits [N+1:2] as the word index.
- R5: Opcode 4 compares R[rs] with R[rt]. If they are equal, the next PC is PC+4 + sign-extended imm16 × 4. Otherwise the next PC is PC+4.
- R6: Opcode 2 sets the PC to {(PC+4)[31:28], target[25:0], 00} and writes neither registers nor memory.
- R7: Register 0 always reads as zero, and writes to it are ignored.
- R8: Any other opcode is a no-op: no register or memory write, and the PC advances by 4.
- R9: A register is written at the end of the cycle, so an instruction that names the same register as source and destination reads the old value.
- R10: `ld_imem`/`ld_dmem` write `ld_data` into the instruction or data word `ld_addr` on the clock edge. A load-port write takes priority over a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_imem | input | 1 | Write `ld_data` into instruction memory |
| ld_dmem | input | 1 | Write `ld_data` into data memory |
| ld_addr | input | LAW | Word index for the load port |
| ld_data | input | 32 | Load port data |
| peek_addr | input | DAW | Data memory word index to observe |
| peek_data | output | 32 | Data word at `peek_addr` |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction being executed |
| wb_en | output | 1 | Instruction writes a register this cycle |
| wb_reg | output | 5 | Destination register number |
| wb_data | output | 32 | Register write data |
| st_en | output | 1 | Instruction stores to data memory this cycle |
| st_addr | output | 32 | ALU result, used as the byte address for memory accesses |
| st_data | output | 32 | Store data, R[rt] |

## Verification
The arithmetic program chains values so that two errors are caught. A mixed-sign operand pair separates signed from unsigned set-less-than. An all-ones immediate separates zero extension from sign extension. Negative load and store offsets show whether the immediate is sign-extended in address generation. The branch program covers a taken forward branch, a not-taken branch and a taken backward branch, which separates the offset scaling and the PC+4 base. The jump program places an unknown opcode whose rt field names a register, a write to register 0 and stores of both, so a spurious write would appear in memory.

// File: rtl/sc_core32.sv
module sc_core32 #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_imem,
  input  logic           ld_dmem,
  input  logic [LAW-1:0] ld_addr,
  input  logic [31:0]    ld_data,
  input  logic [DAW-1:0] peek_addr,
  output logic [31:0]    peek_data,
  output logic [31:0]    pc_o,
  output logic [31:0]    instr_o,
  output logic           wb_en,
  output logic [4:0]     wb_reg,
  output logic [31:0]    wb_data,
  output logic           st_en,
  output logic [31:0]    st_addr,
  output logic [31:0]    st_data
);
  localparam logic [5:0] OP_RT = 6'd0, OP_J = 6'd2, OP_BEQ = 6'd4,
                         OP_ORI = 6'd13, OP_LW = 6'd35, OP_SW = 6'd43;
  localparam logic [2:0] A_ADD = 3'd0, A_SUB = 3'd1, A_AND = 3'd2,
                         A_OR = 3'd3, A_SLT = 3'd4;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf   [32];
  logic [31:0] pc, instr, pc4, ext, opa, opb, alu_y, rd_a, rd_b;
  logic [5:0]  op, fn;
  logic [4:0]  rs, rt, rd;
  logic        reg_dst, alu_src, mem_to_reg, reg_write, mem_write;
  logic        branch, jump, zext, fn_ok;
  logic [1:0]  alu_op;
  logic [2:0]  alu_sel;

  assign instr = imem[pc[IAW+1:2]];
  assign op = instr[31:26];
  assign rs = instr[25:21];
  assign rt = instr[20:16];
  assign rd = instr[15:11];
  assign fn = instr[5:0];

  always_comb begin
    {reg_dst, alu_src, mem_to_reg, reg_write, mem_write, branch, jump, zext} = '0;
    alu_op = 2'b00;
    case (op)
      OP_RT:  begin reg_dst = 1'b1; reg_write = fn_ok; alu_op = 2'b10; end
      OP_LW:  begin alu_src = 1'b1; mem_to_reg = 1'b1; reg_write = 1'b1; end
      OP_SW:  begin alu_src = 1'b1; mem_write = 1'b1; end
      OP_BEQ: begin branch = 1'b1; alu_op = 2'b01; end
      OP_ORI: begin alu_src = 1'b1; reg_write = 1'b1; zext = 1'b1; alu_op = 2'b11; end
      OP_J:   jump = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    fn_ok = 1'b1;
    case (alu_op)
      2'b00: alu_sel = A_ADD;
      2'b01: alu_sel = A_SUB;
      2'b11: alu_sel = A_OR;
      default:
        case (fn)
          6'h20: alu_sel = A_ADD;
          6'h22: alu_sel = A_SUB;
          6'h24: alu_sel = A_AND;
          6'h25: alu_sel = A_OR;
          6'h2A: alu_sel = A_SLT;
          default: begin alu_sel = A_ADD; fn_ok = 1'b0; end
        endcase
    endcase
  end

  assign rd_a = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign rd_b = (rt == 5'd0) ? 32'd0 : rf[rt];
  assign ext  = zext ? {16'd0, instr[15:0]} : {{16{instr[15]}}, instr[15:0]};
  assign opa  = rd_a;
  assign opb  = alu_src ? ext : rd_b;

  always_comb begin
    case (alu_sel)
      A_SUB:   alu_y = opa - opb;
      A_AND:   alu_y = opa & opb;
      A_OR:    alu_y = opa | opb;
      A_SLT:   alu_y = {31'd0, $signed(opa) < $signed(opb)};
      default: alu_y = opa + opb;
    endcase
  end

  assign pc4 = pc + 32'd4;
  assign wb_reg  = reg_dst ? rd : rt;
  assign wb_data = mem_to_reg ? dmem[alu_y[DAW+1:2]] : alu_y;

  always_ff @(posedge clk) begin
    if (rst)
      pc <= '0;
    else if (jump)
      pc <= {pc4[31:28], instr[25:0], 2'b00};
    else if (branch && alu_y == 32'd0)
      pc <= pc4 + {ext[29:0], 2'b00};
    else
      pc <= pc4;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else if (reg_write && wb_reg != 5'd0) begin
      rf[wb_reg] <= wb_data;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_imem) imem[ld_addr[IAW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_dmem)
      dmem[ld_addr[DAW-1:0]] <= ld_data;
    else if (mem_write && !rst)
      dmem[alu_y[DAW+1:2]] <= rd_b;
  end

  assign peek_data = dmem[peek_addr];
  assign pc_o    = pc;
  assign instr_o = instr;
  assign wb_en   = reg_write;
  assign st_en   = mem_write;
  assign st_addr = alu_y;
  assign st_data = rd_b;
endmodule

// File: rtl/sc_core32_chk.sv
module sc_core32_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        wb_en,
  input logic [4:0]  wb_reg,
  input logic        st_en
);
  logic [5:0]  op;
  logic        known;
  logic [31:0] jdest;
  assign op = instr[31:26];
  assign known = op == 6'd0 || op == 6'd2 || op == 6'd4 ||
                 op == 6'd13 || op == 6'd35 || op == 6'd43;
  assign jdest = {pc[31:28] + {3'd0, &pc[27:2]}, instr[25:0], 2'b00};

  // R8
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !known |-> !wb_en && !st_en);
  // R8
  unknown_step_chk: assert property (@(posedge clk) disable iff (rst)
    !known |=> pc == $past(pc) + 32'd4);
  // R6
  jump_dest_chk: assert property (@(posedge clk) disable iff (rst)
    op == 6'd2 |=> pc == $past(jdest));
  // R6
  jump_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    op == 6'd2 |-> !wb_en && !st_en);
  // R4
  store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    st_en |-> !wb_en);
  // R3
  ori_dest_chk: assert property (@(posedge clk) disable iff (rst)
    op == 6'd13 |-> wb_en && wb_reg == instr[20:16]);
  // R2
  rtype_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd0 && wb_en) |-> wb_reg == instr[15:11]);
  // R5
  pc_align_chk: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);
endmodule

bind sc_core32 sc_core32_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc_o), .instr(instr_o),
  .wb_en(wb_en), .wb_reg(wb_reg), .st_en(st_en)
);

// File: tb/test_sc_core32.sv
module test_sc_core32;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_imem = 1'b0, ld_dmem = 1'b0;
  logic [5:0]  ld_addr = '0, peek_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] peek_data, pc_o, instr_o, wb_data, st_addr, st_data;
  logic        wb_en, st_en;
  logic [4:0]  wb_reg;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sc_core32 i_sc_core32 (
    .clk(clk), .rst(rst), .ld_imem(ld_imem), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .peek_addr(peek_addr),
    .peek_data(peek_data), .pc_o(pc_o), .instr_o(instr_o), .wb_en(wb_en),
    .wb_reg(wb_reg), .wb_data(wb_data), .st_en(st_en), .st_addr(st_addr),
    .st_data(st_data)
  );

  function automatic logic [31:0] rt_op(int s, int t, int d, logic [5:0] f);
    return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, f};
  endfunction
  function automatic logic [31:0] im_op(logic [5:0] o, int s, int t, logic [15:0] k);
    return {o, 5'(s), 5'(t), k};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(bit to_i, int idx, logic [31:0] w);
    ld_imem = to_i; ld_dmem = !to_i; ld_addr = 6'(idx); ld_data = w;
    @(negedge clk);
    ld_imem = 1'b0; ld_dmem = 1'b0;
  endtask

  task automatic clear_all();
    rst = 1'b1;
    for (int i = 0; i < 64; i++) put(1'b1, i, 32'd0);
    for (int i = 0; i < 64; i++) put(1'b0, i, 32'd0);
  endtask

  task automatic peek(int idx, string req, logic [31:0] exp);
    peek_addr = 6'(idx); #1;
    chk(req, peek_data, exp);
  endtask

  task automatic go(int n);
    rst = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 pc after reset", pc_o, 32'd0);
  endtask

  task automatic t_alu();
    logic [31:0] p[17];
    clear_all();
    p[0]  = im_op(6'd13, 0, 1, 16'h0007);
    p[1]  = im_op(6'd13, 0, 2, 16'hFFFF);
    p[2]  = rt_op(1, 2, 3, 6'h20);
    p[3]  = rt_op(1, 2, 4, 6'h22);
    p[4]  = rt_op(3, 2, 5, 6'h24);
    p[5]  = rt_op(1, 2, 6, 6'h25);
    p[6]  = rt_op(4, 1, 7, 6'h2A);
    p[7]  = rt_op(1, 4, 8, 6'h2A);
    p[8]  = rt_op(1, 1, 1, 6'h20);
    p[9]  = im_op(6'd43, 0, 3, 16'd0);
    p[10] = im_op(6'd43, 0, 4, 16'd4);
    p[11] = im_op(6'd43, 0, 5, 16'd8);
    p[12] = im_op(6'd43, 0, 6, 16'd12);
    p[13] = im_op(6'd43, 0, 7, 16'd16);
    p[14] = im_op(6'd43, 0, 8, 16'd20);
    p[15] = im_op(6'd43, 0, 1, 16'd24);
    p[16] = im_op(6'd43, 0, 2, 16'd28);
    for (int i = 0; i < 17; i++) put(1'b1, i, p[i]);
    go(17);
    peek(0, "R2 add", 32'h0001_0006);
    peek(1, "R2 sub", 32'hFFFF_0008);
    peek(2, "R2 and", 32'h0000_0006);
    peek(3, "R2 or", 32'h0000_FFFF);
    peek(4, "R2 slt signed true", 32'd1);
    peek(5, "R2 slt signed false", 32'd0);
    peek(6, "R9 same src/dst reads old", 32'd14);
    peek(7, "R3 ori zero-extends", 32'h0000_FFFF);
  endtask

  task automatic t_mem();
    clear_all();
    put(1'b0, 5, 32'hCAFE_BABE);
    peek(5, "R10 load port data word", 32'hCAFE_BABE);
    put(1'b1, 0, im_op(6'd13, 0, 1, 16'd40));
    put(1'b1, 1, im_op(6'd35, 1, 2, 16'hFFEC));
    put(1'b1, 2, im_op(6'd43, 1, 2, 16'd8));
    put(1'b1, 3, im_op(6'd35, 1, 3, 16'd8));
    put(1'b1, 4, im_op(6'd43, 1, 3, 16'hFFDC));
    go(2);
    chk("R4 store enable", {31'd0, st_en}, 32'd1);
    chk("R4 store address", st_addr, 32'd48);
    chk("R4 store data from load", st_data, 32'hCAFE_BABE);
    repeat (3) @(negedge clk);
    peek(12, "R4 store word", 32'hCAFE_BABE);
    peek(1, "R4 negative offset store", 32'hCAFE_BABE);
  endtask

  task automatic t_branch();
    clear_all();
    put(1'b1, 0, im_op(6'd13, 0, 1, 16'd5));
    put(1'b1, 1, im_op(6'd13, 0, 2, 16'd5));
    put(1'b1, 2, im_op(6'd4, 1, 2, 16'd2));
    put(1'b1, 3, im_op(6'd13, 0, 3, 16'd1));
    put(1'b1, 4, im_op(6'd13, 0, 3, 16'd2));
    put(1'b1, 5, im_op(6'd13, 0, 4, 16'd9));
    put(1'b1, 6, im_op(6'd4, 1, 0, 16'd5));
    put(1'b1, 7, im_op(6'd4, 0, 0, 16'hFFFD));
    go(3);
    chk("R5 taken forward", pc_o, 32'd20);
    repeat (2) @(negedge clk);
    chk("R5 not taken", pc_o, 32'd28);
    @(negedge clk);
    chk("R5 taken backward", pc_o, 32'd20);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset mid-run", pc_o, 32'd0);
  endtask

  task automatic t_jump();
    clear_all();
    put(1'b0, 0, 32'hFFFF_FFFF);
    put(1'b0, 1, 32'h0000_0055);
    put(1'b1, 0, {6'd2, 26'd3});
    put(1'b1, 1, im_op(6'd13, 0, 5, 16'd1));
    put(1'b1, 3, im_op(6'h3F, 0, 5, 16'd1));
    put(1'b1, 4, im_op(6'd13, 0, 0, 16'h1234));
    put(1'b1, 5, im_op(6'd43, 0, 0, 16'd0));
    put(1'b1, 6, im_op(6'd43, 0, 5, 16'd4));
    put(1'b1, 7, {6'd2, 26'd0});
    go(1);
    chk("R6 jump target", pc_o, 32'd12);
    chk("R8 unknown no reg write", {31'd0, wb_en}, 32'd0);
    chk("R8 unknown no store", {31'd0, st_en}, 32'd0);
    @(negedge clk);
    chk("R8 unknown pc+4", pc_o, 32'd16);
    repeat (4) @(negedge clk);
    chk("R6 jump to zero", pc_o, 32'd0);
    peek(0, "R7 r0 reads zero after write", 32'd0);
    peek(1, "R8 unknown left rt unwritten", 32'd0);
  endtask

  initial begin
    t_reset();
    t_alu();
    t_mem();
    t_branch();
    t_jump();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule